// File: doc/BRIEF.md
# Serial Real-Time-Clock Register Target

This block is the serial-bus face of a real-time clock. An external controller selects it by raising chip select. It then clocks in a command byte, followed by any number of data bytes. The command names one of sixteen register slots and one of four transfer kinds: a single write, a single read, an auto-incrementing burst write or an auto-incrementing burst read. A burst that starts at slot 0 moves the whole date and time inside one select window, so the controller always sees, or stores, one coherent time.

The seven time fields and the two control registers are held here. The time fields are seconds, minutes, hours, weekday, day, month and year, in slots 0 to 6. The control registers are in slots 14 and 15. A separate counter block reads the current time from `cur_time` and offers each advanced value on `upd_time`. While chip select is high, an offered value is parked. It lands when the window closes, so a burst read never sees a carry half-applied. Two test inputs stand in for the oscillator monitor and the supply monitor. Each one sets a sticky flag in control register 2.

The command decoder is a four-state machine:
- `ST_CMD` collects the command byte. It moves to `ST_RD` when bit 2 of the command is 1, and to `ST_WR` when that bit is 0.
- `ST_WR` and `ST_RD` stay put in burst mode. In single mode they fall to `ST_SKIP` after one data byte.
- `ST_SKIP` ignores everything until chip select drops.
- Any state returns to `ST_CMD` when chip select is low.

Top module: `rtc_spi_target`

## Requirements
- R1: After reset, all time fields read 0, control 1 is 0x00 and control 2 is 0x10 (oscillator-stopped flag set). `mode_24h` is 0 and `spi_miso` is 0.
- R2: In the command byte, bits 7:4 are the register address. Bit 3 = 1 selects single and bit 3 = 0 selects burst. Bit 2 = 1 selects read and bit 2 = 0 selects write. Bits 1:0 are ignored, so 0x8 is a single write, 0xC a single read, 0x0 a burst write and 0x4 a burst read.
- R3: Chip select is active high and SCK idles low. Bytes travel MSB first. The target changes `spi_miso` after each rising SCK edge and samples `spi_mosi` on each falling edge. `spi_miso` is 0 whenever chip select is low.
- R4: A single read returns the addressed register in the byte that follows the command. Later bytes in the same window read 0x00.
- R5: A single write stores the byte that follows the command. Later bytes in the same window change no register.
- R6: A burst read returns successive registers from the command address. The address wraps from 15 to 0.
- R7: A burst write stores successive bytes into successive registers from the command address.
- R8: Stored bits are masked per field. Seconds keep bits 6:0, minutes 6:0, hours 5:0, weekday 2:0, day 5:0 and month bits 7 and 4:0. Year keeps all 8 bits. Slots 7 to 13 read 0x00 and ignore writes.
- R9: In control 2, bit 4 (oscillator stopped) is set by `osc_fail` and bit 6 (low voltage) is set by `low_volt`. Writing 0 to either bit clears it, and writing 1 leaves it unchanged. The other bits of control 2 store what is written.
- R10: `mode_24h` follows bit 5 of control 1.
- R11: With chip select low, an `upd_valid` pulse loads `upd_time` into the time fields on the next clock, with masking applied. Byte i of `upd_time` goes to slot i.
- R12: An update offered while chip select is high changes nothing until chip select falls. It is then applied. It is dropped instead if any time field was written during that window.
- R13: Dropping chip select mid-byte discards the partial byte. The next window starts again with a command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the serial lines are sampled on it |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_cs | input | 1 | Chip select, active high |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_mosi | input | 1 | Serial data from the controller |
| spi_miso | output | 1 | Serial data to the controller |
| upd_valid | input | 1 | One-cycle strobe offering a new time |
| upd_time | input | 56 | Offered time, byte i for slot i |
| osc_fail | input | 1 | Sets the oscillator-stopped flag |
| low_volt | input | 1 | Sets the low-voltage flag |
| cur_time | output | 56 | Current time fields, byte i from slot i |
| mode_24h | output | 1 | 24-hour mode selected |

## Verification
Each `spi_miso` bit is due one clock after a rising SCK edge is seen, and the bench reads it half an SCK period later, just before the falling edge. A written byte reaches `cur_time` three clocks after its last falling edge. A parked update lands one clock after chip select falls, and an idle update lands one clock after its strobe. The bench closes every window and waits several clocks before it looks at `cur_time`, `mode_24h` or `spi_miso`. Read data is compared byte by byte against a queue of expected values filled by the driver.

// File: rtl/rtc_spi_pkg.sv
package rtc_spi_pkg;
    localparam int AW        = 4;
    localparam int DW        = 8;
    localparam int NTIME     = 7;
    localparam int CTL1_ADDR = 14;
    localparam int CTL2_ADDR = 15;
    localparam int OSC_BIT   = 4;
    localparam int LV_BIT    = 6;
    localparam int H24_BIT   = 5;

    typedef enum logic [1:0] {ST_CMD, ST_WR, ST_RD, ST_SKIP} cmd_state_t;

    // bits each slot keeps; zero for unimplemented slots
    function automatic logic [DW-1:0] field_mask(input logic [AW-1:0] a);
        unique case (a)
            4'd0, 4'd1: field_mask = 8'h7F;
            4'd2, 4'd4: field_mask = 8'h3F;
            4'd3:       field_mask = 8'h07;
            4'd5:       field_mask = 8'h9F;
            4'd6:       field_mask = 8'hFF;
            4'd14:      field_mask = 8'hFF;
            4'd15:      field_mask = 8'hFF;
            default:    field_mask = 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/rtc_spi_shifter.sv
module rtc_spi_shifter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic          sck,
    input  logic          mosi,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    output logic          miso,
    output logic          byte_done,
    output logic [DW-1:0] rx_byte
);
    localparam int CW = $clog2(DW);

    logic          sck_q;
    logic [CW-1:0] cnt;
    logic [DW-1:0] rx_sh;
    logic [DW-1:0] tx_sh;
    logic          rise, fall;

    assign rise = cs &&  sck && !sck_q;
    assign fall = cs && !sck &&  sck_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q     <= 1'b0;
            cnt       <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            miso      <= 1'b0;
            byte_done <= 1'b0;
            rx_byte   <= '0;
        end else begin
            sck_q     <= sck;
            byte_done <= 1'b0;
            if (!cs) begin
                cnt   <= '0;
                rx_sh <= '0;
                tx_sh <= '0;
                miso  <= 1'b0;
            end else begin
                if (fall) begin
                    rx_sh <= {rx_sh[DW-2:0], mosi};
                    if (cnt == CW'(DW-1)) begin
                        cnt       <= '0;
                        byte_done <= 1'b1;
                        rx_byte   <= {rx_sh[DW-2:0], mosi};
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                if (rise) begin
                    miso  <= tx_sh[DW-1];
                    tx_sh <= {tx_sh[DW-2:0], 1'b0};
                end
                if (load) tx_sh <= load_data;
            end
        end
    end
endmodule

// File: rtl/rtc_spi_cmd_fsm.sv
module rtc_spi_cmd_fsm
    import rtc_spi_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic          byte_done,
    input  logic [DW-1:0] rx_byte,
    output logic          load,
    output logic [AW-1:0] addr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);
    cmd_state_t state, nxt;
    logic       burst;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_CMD;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (!cs) begin
            nxt = ST_CMD;
        end else begin
            unique case (state)
                ST_CMD:       if (byte_done) nxt = rx_byte[2] ? ST_RD : ST_WR;
                ST_WR, ST_RD: if (byte_done && !burst) nxt = ST_SKIP;
                ST_SKIP:      nxt = ST_SKIP;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst   <= 1'b0;
            addr    <= '0;
            load    <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            load  <= 1'b0;
            wr_en <= 1'b0;
            if (!cs) begin
                burst <= 1'b0;
                addr  <= '0;
            end else if (byte_done) begin
                unique case (state)
                    ST_CMD: begin
                        addr  <= rx_byte[DW-1:DW-AW];
                        burst <= !rx_byte[3];
                        load  <= rx_byte[2];
                    end
                    ST_WR: begin
                        wr_en   <= 1'b1;
                        wr_addr <= addr;
                        wr_data <= rx_byte;
                        addr    <= addr + 1'b1;
                    end
                    ST_RD: begin
                        addr <= addr + 1'b1;
                        load <= burst;
                    end
                    ST_SKIP: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
    import rtc_spi_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic [DW-1:0]       wr_data,
    input  logic [AW-1:0]       rd_addr,
    output logic [DW-1:0]       rd_data,
    input  logic                upd_valid,
    input  logic [NTIME*DW-1:0] upd_time,
    input  logic                osc_fail,
    input  logic                low_volt,
    output logic [NTIME*DW-1:0] cur_time,
    output logic                mode_24h,
    output logic [DW-1:0]       ctl2_q
);
    logic [DW-1:0]       tr [NTIME];
    logic [DW-1:0]       ctl1_q;
    logic [DW-1:0]       ctl2_nxt;
    logic [NTIME*DW-1:0] pend_time;
    logic                pend, time_wr, cs_q, release_apply;

    assign release_apply = !cs && cs_q && pend && !time_wr;
    assign mode_24h      = ctl1_q[H24_BIT];

    for (genvar g = 0; g < NTIME; g++) begin : g_out
        assign cur_time[g*DW +: DW] = tr[g];
    end

    always_comb begin
        ctl2_nxt = ctl2_q;
        if (wr_en && wr_addr == AW'(CTL2_ADDR)) begin
            ctl2_nxt          = wr_data;
            ctl2_nxt[OSC_BIT] = wr_data[OSC_BIT] & ctl2_q[OSC_BIT];
            ctl2_nxt[LV_BIT]  = wr_data[LV_BIT]  & ctl2_q[LV_BIT];
        end
        ctl2_nxt[OSC_BIT] = ctl2_nxt[OSC_BIT] | osc_fail;
        ctl2_nxt[LV_BIT]  = ctl2_nxt[LV_BIT]  | low_volt;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NTIME; i++)
            if (rd_addr == AW'(i)) rd_data = tr[i];
        if (rd_addr == AW'(CTL1_ADDR)) rd_data = ctl1_q;
        if (rd_addr == AW'(CTL2_ADDR)) rd_data = ctl2_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NTIME; i++) tr[i] <= '0;
            ctl1_q    <= '0;
            ctl2_q    <= DW'(1) << OSC_BIT;
            pend      <= 1'b0;
            pend_time <= '0;
            time_wr   <= 1'b0;
            cs_q      <= 1'b0;
        end else begin
            cs_q   <= cs;
            ctl2_q <= ctl2_nxt;
            if (cs) begin
                if (upd_valid) begin
                    pend      <= 1'b1;
                    pend_time <= upd_time;
                end
                if (wr_en && wr_addr < AW'(NTIME)) time_wr <= 1'b1;
            end else begin
                pend    <= 1'b0;
                time_wr <= 1'b0;
            end
            for (int i = 0; i < NTIME; i++) begin
                if (release_apply)
                    tr[i] <= pend_time[i*DW +: DW] & field_mask(AW'(i));
                if (!cs && upd_valid)
                    tr[i] <= upd_time[i*DW +: DW] & field_mask(AW'(i));
                if (wr_en && wr_addr == AW'(i))
                    tr[i] <= wr_data & field_mask(AW'(i));
            end
            if (wr_en && wr_addr == AW'(CTL1_ADDR)) ctl1_q <= wr_data;
        end
    end
endmodule

// File: rtl/rtc_spi_target.sv
module rtc_spi_target
    import rtc_spi_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                spi_cs,
    input  logic                spi_sck,
    input  logic                spi_mosi,
    output logic                spi_miso,
    input  logic                upd_valid,
    input  logic [NTIME*DW-1:0] upd_time,
    input  logic                osc_fail,
    input  logic                low_volt,
    output logic [NTIME*DW-1:0] cur_time,
    output logic                mode_24h
);
    logic          byte_done, load, wr_en;
    logic [DW-1:0] rx_byte, rd_data, wr_data, ctl2_q;
    logic [AW-1:0] addr, wr_addr;

    rtc_spi_shifter #(.DW(DW)) u_shift (
        .clk(clk), .rst_n(rst_n), .cs(spi_cs), .sck(spi_sck), .mosi(spi_mosi),
        .load(load), .load_data(rd_data), .miso(spi_miso),
        .byte_done(byte_done), .rx_byte(rx_byte)
    );

    rtc_spi_cmd_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cs(spi_cs), .byte_done(byte_done),
        .rx_byte(rx_byte), .load(load), .addr(addr), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    rtc_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .cs(spi_cs), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(addr), .rd_data(rd_data),
        .upd_valid(upd_valid), .upd_time(upd_time), .osc_fail(osc_fail),
        .low_volt(low_volt), .cur_time(cur_time), .mode_24h(mode_24h),
        .ctl2_q(ctl2_q)
    );
endmodule

// File: rtl/rtc_spi_target_chk.sv
module rtc_spi_target_chk #(
    parameter int TW = 56
) (
    input logic          clk,
    input logic          rst_n,
    input logic          spi_cs,
    input logic          spi_miso,
    input logic [TW-1:0] cur_time,
    input logic          wr_en,
    input logic [7:0]    ctl2_q,
    input logic          osc_fail,
    input logic          low_volt
);
    assert_miso_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs |=> !spi_miso);

    assert_time_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs && !wr_en) |=> $stable(cur_time));

    assert_osc_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        osc_fail |=> ctl2_q[4]);

    assert_lv_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        low_volt |=> ctl2_q[6]);
endmodule

bind rtc_spi_target rtc_spi_target_chk #(.TW(56)) u_chk (
    .clk(clk), .rst_n(rst_n), .spi_cs(spi_cs), .spi_miso(spi_miso),
    .cur_time(cur_time), .wr_en(wr_en), .ctl2_q(ctl2_q),
    .osc_fail(osc_fail), .low_volt(low_volt)
);

// File: tb/tb_rtc_spi_target.sv
module tb_rtc_spi_target;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_cs = 1'b0, spi_sck = 1'b0, spi_mosi = 1'b0;
    logic        spi_miso;
    logic        upd_valid = 1'b0;
    logic [55:0] upd_time = '0;
    logic        osc_fail = 1'b0, low_volt = 1'b0;
    logic [55:0] cur_time;
    logic        mode_24h;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    typedef struct {
        bit         chk;
        logic [7:0] v;
        string      tag;
    } item_t;
    item_t      exp_q[$];
    logic [7:0] got_byte;
    event       got_ev;
    logic [7:0] model [7];

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_spi_target dut (
        .clk(clk), .rst_n(rst_n), .spi_cs(spi_cs), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .upd_valid(upd_valid),
        .upd_time(upd_time), .osc_fail(osc_fail), .low_volt(low_volt),
        .cur_time(cur_time), .mode_24h(mode_24h)
    );

    function automatic logic [55:0] packed_model();
        logic [55:0] p;
        for (int i = 0; i < 7; i++) p[i*8 +: 8] = model[i];
        return p;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clk_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_on();
        clk_n(HALF); spi_cs = 1'b1; clk_n(HALF);
    endtask

    task automatic cs_off();
        clk_n(HALF); spi_cs = 1'b0; clk_n(2*HALF);
    endtask

    task automatic bit_x(input logic b, output logic o);
        spi_mosi = b;
        clk_n(HALF);
        spi_sck = 1'b1;
        clk_n(HALF);
        o = spi_miso;
        spi_sck = 1'b0;
        clk_n(HALF);
    endtask

    task automatic xfer(input logic [7:0] tx, input bit chk, input logic [7:0] exp, input string tag);
        logic [7:0] rx;
        item_t it;
        it.chk = chk; it.v = exp; it.tag = tag;
        exp_q.push_back(it);
        for (int b = 7; b >= 0; b--) bit_x(tx[b], rx[b]);
        got_byte = rx;
        ->got_ev;
    endtask

    task automatic pulse_upd(input logic [55:0] t);
        upd_time = t; upd_valid = 1'b1;
        clk_n(1);
        upd_valid = 1'b0;
    endtask

    // monitor: pops one expected item for every byte the driver completes
    initial begin
        forever begin
            @(got_ev);
            if (exp_q.size() == 0) begin
                check(1'b0, "scoreboard underflow", 64'(got_byte), 64'h0);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                if (it.chk) check(got_byte === it.v, it.tag, 64'(got_byte), 64'(it.v));
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic o;
        logic [55:0] t;
        for (int i = 0; i < 7; i++) model[i] = 8'h00;
        clk_n(4);
        rst_n = 1'b1;
        clk_n(2);

        // R1 reset state at the ports
        check(cur_time === 56'h0, "R1 cur_time reset", 64'(cur_time), 64'h0);
        check(mode_24h === 1'b0, "R1 mode_24h reset", 64'(mode_24h), 64'h0);
        check(spi_miso === 1'b0, "R1 miso reset", 64'(spi_miso), 64'h0);

        // R1/R4 single read of control 2
        cs_on();
        xfer(8'hFC, 0, 8'h00, "cmd");
        xfer(8'h00, 1, 8'h10, "R1 R4 control2 reset value");
        cs_off();

        // R5 R8 single write of seconds, masked; trailing byte ignored
        cs_on();
        xfer(8'h08, 0, 8'h00, "cmd");
        xfer(8'hD9, 0, 8'h00, "data");
        xfer(8'h11, 0, 8'h00, "extra");
        cs_off();
        model[0] = 8'h59;
        check(cur_time === packed_model(), "R5 R8 single write masked, extra ignored", 64'(cur_time), 64'(packed_model()));

        // R7 burst write of all time fields
        cs_on();
        xfer(8'h00, 0, 8'h00, "cmd");
        xfer(8'h30, 0, 8'h00, "d"); xfer(8'h45, 0, 8'h00, "d");
        xfer(8'h12, 0, 8'h00, "d"); xfer(8'h03, 0, 8'h00, "d");
        xfer(8'h28, 0, 8'h00, "d"); xfer(8'h92, 0, 8'h00, "d");
        xfer(8'h24, 0, 8'h00, "d");
        cs_off();
        model[0] = 8'h30; model[1] = 8'h45; model[2] = 8'h12; model[3] = 8'h03;
        model[4] = 8'h28; model[5] = 8'h92; model[6] = 8'h24;
        check(cur_time === packed_model(), "R7 burst write", 64'(cur_time), 64'(packed_model()));

        // R6 burst read across all slots with wrap 15 -> 0
        cs_on();
        xfer(8'h04, 0, 8'h00, "cmd");
        for (int i = 0; i < 7; i++) xfer(8'h00, 1, model[i], "R6 burst read time field");
        for (int i = 7; i < 14; i++) xfer(8'h00, 1, 8'h00, "R6 R8 burst read empty slot");
        xfer(8'h00, 1, 8'h00, "R6 burst read control1");
        xfer(8'h00, 1, 8'h10, "R6 burst read control2");
        xfer(8'h00, 1, model[0], "R6 burst wrap to slot 0");
        cs_off();

        // R2 low command bits ignored; R4 trailing byte reads zero
        cs_on();
        xfer(8'h2F, 0, 8'h00, "cmd");
        xfer(8'h00, 1, 8'h12, "R2 single read with bits1:0 set");
        xfer(8'h00, 1, 8'h00, "R4 byte after single read");
        cs_off();

        // R8 unimplemented slot and minute mask
        cs_on(); xfer(8'h88, 0, 8'h00, "cmd"); xfer(8'h55, 0, 8'h00, "d"); cs_off();
        cs_on(); xfer(8'h8C, 0, 8'h00, "cmd"); xfer(8'h00, 1, 8'h00, "R8 slot 8 reads zero"); cs_off();
        cs_on(); xfer(8'h18, 0, 8'h00, "cmd"); xfer(8'hFF, 0, 8'h00, "d"); cs_off();
        model[1] = 8'h7F;
        check(cur_time === packed_model(), "R8 minute mask", 64'(cur_time), 64'(packed_model()));

        // R10 24-hour select
        cs_on(); xfer(8'hE8, 0, 8'h00, "cmd"); xfer(8'h20, 0, 8'h00, "d"); cs_off();
        check(mode_24h === 1'b1, "R10 mode_24h set", 64'(mode_24h), 64'h1);
        cs_on(); xfer(8'hEC, 0, 8'h00, "cmd"); xfer(8'h00, 1, 8'h20, "R10 control1 readback"); cs_off();

        // R9 flags in control 2
        cs_on(); xfer(8'hF8, 0, 8'h00, "cmd"); xfer(8'h00, 0, 8'h00, "d"); cs_off();
        cs_on(); xfer(8'hFC, 0, 8'h00, "cmd"); xfer(8'h00, 1, 8'h00, "R9 flags cleared by writing 0"); cs_off();
        low_volt = 1'b1; clk_n(1); low_volt = 1'b0; clk_n(2);
        cs_on(); xfer(8'hFC, 0, 8'h00, "cmd"); xfer(8'h00, 1, 8'h40, "R9 low-voltage flag set"); cs_off();
        cs_on(); xfer(8'hF8, 0, 8'h00, "cmd"); xfer(8'hFF, 0, 8'h00, "d"); cs_off();
        cs_on(); xfer(8'hFC, 0, 8'h00, "cmd"); xfer(8'h00, 1, 8'hEF, "R9 writing 1 does not set osc flag"); cs_off();
        osc_fail = 1'b1; clk_n(1); osc_fail = 1'b0; clk_n(2);
        cs_on(); xfer(8'hFC, 0, 8'h00, "cmd"); xfer(8'h00, 1, 8'hFF, "R9 oscillator flag set"); cs_off();

        // R11 idle update applied with masks
        t = {8'h25, 8'h06, 8'h15, 8'h02, 8'h07, 8'h12, 8'h85};
        pulse_upd(t);
        clk_n(1);
        model[0] = 8'h05; model[1] = 8'h12; model[2] = 8'h07; model[3] = 8'h02;
        model[4] = 8'h15; model[5] = 8'h06; model[6] = 8'h25;
        check(cur_time === packed_model(), "R11 idle update", 64'(cur_time), 64'(packed_model()));

        // R12 update held during window, applied on release
        cs_on();
        t = {8'h26, 8'h07, 8'h16, 8'h03, 8'h08, 8'h13, 8'h10};
        pulse_upd(t);
        clk_n(4);
        check(cur_time === packed_model(), "R12 update held while selected", 64'(cur_time), 64'(packed_model()));
        cs_off();
        model[0] = 8'h10; model[1] = 8'h13; model[2] = 8'h08; model[3] = 8'h03;
        model[4] = 8'h16; model[5] = 8'h07; model[6] = 8'h26;
        check(cur_time === packed_model(), "R12 held update applied at release", 64'(cur_time), 64'(packed_model()));

        // R12 held update dropped after a time write in the same window
        cs_on();
        pulse_upd({8'h27, 8'h08, 8'h17, 8'h04, 8'h09, 8'h14, 8'h20});
        xfer(8'h08, 0, 8'h00, "cmd");
        xfer(8'h33, 0, 8'h00, "d");
        cs_off();
        model[0] = 8'h33;
        check(cur_time === packed_model(), "R12 held update dropped after write", 64'(cur_time), 64'(packed_model()));

        // R13 partial byte discarded
        cs_on();
        for (int b = 0; b < 4; b++) bit_x(1'b1, o);
        cs_off();
        cs_on();
        xfer(8'h2C, 0, 8'h00, "cmd");
        xfer(8'h00, 1, model[2], "R13 fresh command after partial byte");
        cs_off();

        // R3 miso idle after window
        check(spi_miso === 1'b0, "R3 miso low when deselected", 64'(spi_miso), 64'h0);

        clk_n(4);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule